// File: doc/BRIEF.md
# Banked Private Peripheral Address Decoder

This block sits in front of a 4 KB register window that is private to a cluster of up to four cores. Each access arrives as a bus address, the ID of the core that issued it, read and write strobes and write data. The decoder sends the access to one of three places. The first is a small set of snoop-control registers that the block holds itself. The second is the per-core interface of an interrupt controller. The third is one of eight timer or watchdog instances, two for each core. Only the low 12 bits of the address take part in the decode.

Two aliasing schemes reach the interrupt interface and the timers. A "self" page resolves to the registers of whichever core makes the request. A run of explicit pages, one per core at a 256-byte stride, reaches a named core no matter who asks. Inside a timer page, address bit 5 chooses the watchdog of the pair instead of the plain timer. The interrupt controller and the timers sit outside the block. They see a one-cycle strobe with a core or instance index and a local offset, and they return read data in the same cycle.

Every access gets a response one cycle later. The response carries the registered read data and a one-cycle error flag for unmapped offsets. The read data is zero when the error flag is set.

Top module: `ppwin_decoder`

## Requirements
- R1: Only address bits 11:0 are decoded. Two addresses that share those bits reach the same target with the same index and offset.
- R2: Offset 0x000 is a control register with one bit. A write keeps only data bit 0. A read returns that bit in bit 0 and zeros above it. The bit is 0 after reset.
- R3: Offset 0x004 reads the configuration word 0xF3. Offsets 0x008 and 0x00C read 0. A write to 0x00C completes without error and changes nothing: the control bit at 0x000 keeps its value.
- R4: In page 0 (offsets 0x000 to 0x0FF), a read of any offset other than 0x000, 0x004, 0x008 or 0x00C is an error. A write to any offset other than 0x000 or 0x00C is also an error. An errored access changes no state.
- R5: Offsets 0x100 to 0x1FF strobe the interrupt interface. The core index equals the requester's ID, and the local offset is address bits 7:0.
- R6: Offsets 0x200 to 0x5FF strobe the interrupt interface. The core index is address bits 11:8 minus 2, and the local offset is address bits 7:0.
- R7: Offsets 0x600 to 0x6FF select the timers of the requesting core. Offsets 0x700 to 0xAFF select core (bits 11:8 minus 7). The instance index is core×2 + address bit 5, and the register offset is address bits 3:0.
- R8: A read at offset 0xB00 or above is an error. A write there completes without error and strobes nothing.
- R9: A read or write in cycle N gives a response in cycle N+1. The response carries the error flag and the read data that the selected source had in cycle N. Read data is zero on an error and on every write. A cycle with no request gives no response.
- R10: When read and write are asserted together, the access is handled as a read only.
- R11: At most one of the four downstream strobes (interrupt read or write, timer read or write) is high in any cycle. None is high when the block is idle or the access is in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | ADDR_W | Access address; bits 11:0 are decoded |
| req_core | input | 2 | ID of the requesting core |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | DATA_W | Write data |
| dn_wdata | output | DATA_W | Write data forwarded to the downstream targets |
| ifc_rd | output | 1 | Interrupt interface read strobe |
| ifc_wr | output | 1 | Interrupt interface write strobe |
| ifc_core | output | 2 | Interrupt interface core index |
| ifc_off | output | 8 | Interrupt interface local offset |
| ifc_rdata | input | DATA_W | Interrupt interface read data, valid in the strobe cycle |
| tmr_rd | output | 1 | Timer read strobe |
| tmr_wr | output | 1 | Timer write strobe |
| tmr_idx | output | 3 | Timer instance index (core×2 + watchdog select) |
| tmr_off | output | 4 | Timer register offset |
| tmr_rdata | input | DATA_W | Timer read data, valid in the strobe cycle |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | DATA_W | Registered response read data |

## Verification
The assertions check a set of properties on every cycle. At most one downstream strobe is high, and a read suppresses all write strobes. Each request gets a response on the next cycle, and idle cycles produce no response. Error responses carry zero data, a read at 0xB00 or above always errors, the "self" timer page indexes the requester's own timer pair, and the configuration word comes back for a read of 0x004. Some behaviours can be shown only by the bench's scenarios: the exact core and offset arithmetic of the explicit windows, the watchdog bit, aliasing of the upper address bits, and the control bit keeping only bit 0. The bench also shows that writes which error or are ignored leave that bit as it was.

// File: rtl/ppwin_pkg.sv
package ppwin_pkg;

   localparam int MAX_CORES  = 4;
   localparam int CORE_IDX_W = 2;
   localparam int LOC_W      = 8;
   localparam int WIN_W      = 12;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SCU  = 2'd1,
      TGT_IFC  = 2'd2,
      TGT_TMR  = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e                  tgt;
      logic [CORE_IDX_W-1:0] core;
      logic                  wdog;
      logic [LOC_W-1:0]      loc;
      logic                  bad_rd;
      logic                  bad_wr;
   } dec_t;

endpackage

// File: rtl/ppwin_region_decode.sv
module ppwin_region_decode
   import ppwin_pkg::*;
#(
   parameter int N_CORES = 4,
   parameter int ADDR_W  = 32
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [CORE_IDX_W-1:0] core_id,
   output dec_t                  dec
);

   localparam logic [3:0] PG_SELF_IFC  = 4'd1;
   localparam logic [3:0] PG_LAST_IFC  = 4'd5;
   localparam logic [3:0] PG_SELF_TMR  = 4'd6;
   localparam logic [3:0] PG_LAST_TMR  = 4'd10;
   localparam logic [3:0] IFC_BASE_PG  = 4'd2;
   localparam logic [3:0] TMR_BASE_PG  = 4'd7;

   logic [WIN_W-1:0]      win;
   logic [3:0]            page;
   logic [3:0]            ifc_rel;
   logic [3:0]            tmr_rel;
   logic [CORE_IDX_W-1:0] core_pick;
   logic                  core_bad;

   assign win     = addr[WIN_W-1:0];
   assign page    = win[WIN_W-1:8];
   assign ifc_rel = page - IFC_BASE_PG;
   assign tmr_rel = page - TMR_BASE_PG;

   always_comb begin
      if (page == PG_SELF_IFC || page == PG_SELF_TMR) begin
         core_pick = core_id;
      end else if (page <= PG_LAST_IFC) begin
         core_pick = ifc_rel[CORE_IDX_W-1:0];
      end else begin
         core_pick = tmr_rel[CORE_IDX_W-1:0];
      end
   end

   generate
      if (N_CORES == MAX_CORES) begin : g_full
         assign core_bad = 1'b0;
      end else begin : g_partial
         assign core_bad = (32'(core_pick) >= N_CORES);
      end
   endgenerate

   always_comb begin
      dec        = '0;
      dec.loc    = win[LOC_W-1:0];
      dec.wdog   = win[5];
      dec.core   = core_pick;
      if (page == 4'd0) begin
         dec.tgt    = TGT_SCU;
         dec.bad_rd = !(win[7:0] inside {8'h00, 8'h04, 8'h08, 8'h0C});
         dec.bad_wr = !(win[7:0] inside {8'h00, 8'h0C});
      end else if (page <= PG_LAST_IFC) begin
         dec.tgt    = TGT_IFC;
         dec.bad_rd = core_bad;
         dec.bad_wr = core_bad;
      end else if (page <= PG_LAST_TMR) begin
         dec.tgt    = TGT_TMR;
         dec.bad_rd = core_bad;
         dec.bad_wr = core_bad;
      end else begin
         dec.tgt    = TGT_NONE;
         dec.bad_rd = 1'b1;
         dec.bad_wr = 1'b0;
      end
   end

endmodule

// File: rtl/ppwin_scu_regs.sv
module ppwin_scu_regs
   import ppwin_pkg::*;
#(
   parameter int              DATA_W   = 32,
   parameter logic [DATA_W-1:0] CFG_WORD = 32'h0000_00F3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [LOC_W-1:0]  loc,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= 1'b0;
      end else if (wr_en && loc == 8'h00) begin
         ctl_q <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (loc)
            8'h00:   rdata = {{(DATA_W-1){1'b0}}, ctl_q};
            8'h04:   rdata = CFG_WORD;
            default: rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/ppwin_rsp_stage.sv
module ppwin_rsp_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              rd,
   input  logic              err,
   input  logic [DATA_W-1:0] rdata_in,
   output logic              valid_q,
   output logic              err_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         valid_q <= acc;
         err_q   <= acc & err;
         rdata_q <= (acc && rd && !err) ? rdata_in : '0;
      end
   end

endmodule

// File: rtl/ppwin_decoder.sv
module ppwin_decoder
   import ppwin_pkg::*;
#(
   parameter int                N_CORES  = 4,
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] CFG_WORD = 32'h0000_00F3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_core,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] dn_wdata,
   output logic              ifc_rd,
   output logic              ifc_wr,
   output logic [1:0]        ifc_core,
   output logic [7:0]        ifc_off,
   input  logic [DATA_W-1:0] ifc_rdata,
   output logic              tmr_rd,
   output logic              tmr_wr,
   output logic [2:0]        tmr_idx,
   output logic [3:0]        tmr_off,
   input  logic [DATA_W-1:0] tmr_rdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);

   generate
      if (N_CORES < 1 || N_CORES > MAX_CORES) begin : g_bad_cores
         $error("ppwin_decoder: N_CORES must be 1..4");
      end
      if (ADDR_W < WIN_W) begin : g_bad_addr
         $error("ppwin_decoder: ADDR_W must cover the 12-bit window");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("ppwin_decoder: DATA_W must hold the configuration byte");
      end
   endgenerate

   dec_t              dec;
   logic              acc_rd;
   logic              acc_wr;
   logic              acc;
   logic              acc_err;
   logic              go;
   logic [DATA_W-1:0] scu_rdata;
   logic [DATA_W-1:0] sel_rdata;

   ppwin_region_decode #(
      .N_CORES (N_CORES),
      .ADDR_W  (ADDR_W)
   ) u_dec (
      .addr    (req_addr),
      .core_id (req_core),
      .dec     (dec)
   );

   // Read wins when both strobes are raised.
   assign acc_rd  = req_rd;
   assign acc_wr  = req_wr & ~req_rd;
   assign acc     = acc_rd | acc_wr;
   assign acc_err = (acc_rd & dec.bad_rd) | (acc_wr & dec.bad_wr);
   assign go      = acc & ~acc_err;

   ppwin_scu_regs #(
      .DATA_W   (DATA_W),
      .CFG_WORD (CFG_WORD)
   ) u_scu (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (go & acc_wr & (dec.tgt == TGT_SCU)),
      .rd_en (go & acc_rd & (dec.tgt == TGT_SCU)),
      .loc   (dec.loc),
      .wdata (req_wdata),
      .rdata (scu_rdata)
   );

   assign ifc_rd   = go & acc_rd & (dec.tgt == TGT_IFC);
   assign ifc_wr   = go & acc_wr & (dec.tgt == TGT_IFC);
   assign ifc_core = dec.core;
   assign ifc_off  = dec.loc;

   assign tmr_rd   = go & acc_rd & (dec.tgt == TGT_TMR);
   assign tmr_wr   = go & acc_wr & (dec.tgt == TGT_TMR);
   assign tmr_idx  = {dec.core, dec.wdog};
   assign tmr_off  = dec.loc[3:0];

   assign dn_wdata = req_wdata;

   always_comb begin
      unique case (dec.tgt)
         TGT_SCU: sel_rdata = scu_rdata;
         TGT_IFC: sel_rdata = ifc_rdata;
         TGT_TMR: sel_rdata = tmr_rdata;
         default: sel_rdata = '0;
      endcase
   end

   ppwin_rsp_stage #(
      .DATA_W (DATA_W)
   ) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .rd       (acc_rd),
      .err      (acc_err),
      .rdata_in (sel_rdata),
      .valid_q  (rsp_valid),
      .err_q    (rsp_err),
      .rdata_q  (rsp_rdata)
   );

endmodule

// File: rtl/ppwin_decoder_chk.sv
module ppwin_decoder_chk #(
   parameter int                N_CORES  = 4,
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] CFG_WORD = 32'h0000_00F3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_core,
   input logic              req_rd,
   input logic              req_wr,
   input logic              ifc_rd,
   input logic              ifc_wr,
   input logic              tmr_rd,
   input logic              tmr_wr,
   input logic [2:0]        tmr_idx,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata
);

   logic [3:0] pg;
   assign pg = req_addr[11:8];

   p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd || req_wr) |=> rsp_valid);

   p_no_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_rd || req_wr) |=> !rsp_valid);

   p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));

   p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ifc_rd, ifc_wr, tmr_rd, tmr_wr}));

   p_rd_over_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_rd |-> (!ifc_wr && !tmr_wr));

   p_high_read_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd && pg >= 4'd11) |=> rsp_err);

   p_self_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_rd || req_wr) && pg == 4'd6 && 32'(req_core) < N_CORES)
      |-> ((tmr_rd || tmr_wr) && tmr_idx[2:1] == req_core));

   p_cfg_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd && req_addr[11:0] == 12'h004) |=> (rsp_rdata == CFG_WORD && !rsp_err));

endmodule

bind ppwin_decoder ppwin_decoder_chk #(
   .N_CORES  (N_CORES),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CFG_WORD (CFG_WORD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_addr  (req_addr),
   .req_core  (req_core),
   .req_rd    (req_rd),
   .req_wr    (req_wr),
   .ifc_rd    (ifc_rd),
   .ifc_wr    (ifc_wr),
   .tmr_rd    (tmr_rd),
   .tmr_wr    (tmr_wr),
   .tmr_idx   (tmr_idx),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata)
);

// File: tb/ppwin_decoder_tb.sv
module ppwin_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_core = '0;
   logic        req_rd = 1'b0;
   logic        req_wr = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [31:0] dn_wdata;
   logic        ifc_rd, ifc_wr;
   logic [1:0]  ifc_core;
   logic [7:0]  ifc_off;
   logic [31:0] ifc_rdata;
   logic        tmr_rd, tmr_wr;
   logic [2:0]  tmr_idx;
   logic [3:0]  tmr_off;
   logic [31:0] tmr_rdata;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   // Peripheral models: read data encodes the index and offset they were given.
   assign ifc_rdata = {8'hA0, 14'd0, ifc_core, ifc_off};
   assign tmr_rdata = {8'hB0, 13'd0, tmr_idx, 4'd0, tmr_off};

   ppwin_decoder u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_addr  (req_addr),
      .req_core  (req_core),
      .req_rd    (req_rd),
      .req_wr    (req_wr),
      .req_wdata (req_wdata),
      .dn_wdata  (dn_wdata),
      .ifc_rd    (ifc_rd),
      .ifc_wr    (ifc_wr),
      .ifc_core  (ifc_core),
      .ifc_off   (ifc_off),
      .ifc_rdata (ifc_rdata),
      .tmr_rd    (tmr_rd),
      .tmr_wr    (tmr_wr),
      .tmr_idx   (tmr_idx),
      .tmr_off   (tmr_off),
      .tmr_rdata (tmr_rdata),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   // kind: 0 = no downstream strobe, 1 = interrupt interface, 2 = timer
   typedef struct packed {
      logic [3:0]  req;
      logic        rd;
      logic        wr;
      logic [1:0]  core;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [1:0]  kind;
      logic [2:0]  sel;
      logic [7:0]  off;
      logic        err;
      logic [31:0] rdata;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      // R5 self interrupt page
      '{4'd5, 1'b1, 1'b0, 2'd2, 32'h0000_0104, 32'h0, 2'd1, 3'd2, 8'h04, 1'b0, 32'hA000_0204},
      '{4'd5, 1'b1, 1'b0, 2'd0, 32'h0000_01FC, 32'h0, 2'd1, 3'd0, 8'hFC, 1'b0, 32'hA000_00FC},
      // R6 explicit interrupt pages
      '{4'd6, 1'b1, 1'b0, 2'd3, 32'h0000_0210, 32'h0, 2'd1, 3'd0, 8'h10, 1'b0, 32'hA000_0010},
      '{4'd6, 1'b1, 1'b0, 2'd0, 32'h0000_05F0, 32'h0, 2'd1, 3'd3, 8'hF0, 1'b0, 32'hA000_03F0},
      '{4'd6, 1'b0, 1'b1, 2'd0, 32'h0000_0300, 32'hDEAD_BEEF, 2'd1, 3'd1, 8'h00, 1'b0, 32'h0},
      // R7 timer pages, watchdog on bit 5
      '{4'd7, 1'b1, 1'b0, 2'd1, 32'h0000_060C, 32'h0, 2'd2, 3'd2, 8'h0C, 1'b0, 32'hB000_020C},
      '{4'd7, 1'b1, 1'b0, 2'd1, 32'h0000_0628, 32'h0, 2'd2, 3'd3, 8'h08, 1'b0, 32'hB000_0308},
      '{4'd7, 1'b1, 1'b0, 2'd2, 32'h0000_0704, 32'h0, 2'd2, 3'd0, 8'h04, 1'b0, 32'hB000_0004},
      '{4'd7, 1'b1, 1'b0, 2'd0, 32'h0000_0A2C, 32'h0, 2'd2, 3'd7, 8'h0C, 1'b0, 32'hB000_070C},
      '{4'd7, 1'b0, 1'b1, 2'd3, 32'h0000_0834, 32'h0000_0055, 2'd2, 3'd3, 8'h04, 1'b0, 32'h0},
      // R3 fixed control-page reads
      '{4'd3, 1'b1, 1'b0, 2'd0, 32'h0000_0004, 32'h0, 2'd0, 3'd0, 8'h00, 1'b0, 32'h0000_00F3},
      '{4'd3, 1'b1, 1'b0, 2'd0, 32'h0000_0008, 32'h0, 2'd0, 3'd0, 8'h00, 1'b0, 32'h0},
      '{4'd3, 1'b1, 1'b0, 2'd0, 32'h0000_000C, 32'h0, 2'd0, 3'd0, 8'h00, 1'b0, 32'h0},
      // R4 undefined control-page offsets
      '{4'd4, 1'b1, 1'b0, 2'd0, 32'h0000_0010, 32'h0, 2'd0, 3'd0, 8'h00, 1'b1, 32'h0},
      '{4'd4, 1'b0, 1'b1, 2'd0, 32'h0000_0004, 32'h1, 2'd0, 3'd0, 8'h00, 1'b1, 32'h0},
      // R8 top of window
      '{4'd8, 1'b1, 1'b0, 2'd0, 32'h0000_0B00, 32'h0, 2'd0, 3'd0, 8'h00, 1'b1, 32'h0},
      '{4'd8, 1'b1, 1'b0, 2'd1, 32'h0000_0FFC, 32'h0, 2'd0, 3'd0, 8'h00, 1'b1, 32'h0},
      '{4'd8, 1'b0, 1'b1, 2'd0, 32'h0000_0B40, 32'h7, 2'd0, 3'd0, 8'h00, 1'b0, 32'h0},
      // R1 upper address bits ignored
      '{4'd1, 1'b1, 1'b0, 2'd3, 32'h1234_5104, 32'h0, 2'd1, 3'd3, 8'h04, 1'b0, 32'hA000_0304},
      '{4'd1, 1'b1, 1'b0, 2'd1, 32'hFFFF_F62C, 32'h0, 2'd2, 3'd3, 8'h0C, 1'b0, 32'hB000_030C}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, check strobes mid-cycle, check the response after
   // the next rising edge.
   task automatic run_acc(input vec_t v);
      string tag;
      bit    eff_wr;
      tag    = $sformatf("R%0d @%h", v.req, v.addr);
      eff_wr = v.wr && !v.rd;
      @(negedge clk);
      req_addr  = v.addr;
      req_core  = v.core;
      req_rd    = v.rd;
      req_wr    = v.wr;
      req_wdata = v.wdata;
      #2;
      chk(ifc_rd == (v.rd && v.kind == 2'd1), {tag, " ifc_rd"}, 32'(ifc_rd), 32'(v.rd && v.kind == 2'd1));
      chk(ifc_wr == (eff_wr && v.kind == 2'd1), {tag, " ifc_wr"}, 32'(ifc_wr), 32'(eff_wr && v.kind == 2'd1));
      chk(tmr_rd == (v.rd && v.kind == 2'd2), {tag, " tmr_rd"}, 32'(tmr_rd), 32'(v.rd && v.kind == 2'd2));
      chk(tmr_wr == (eff_wr && v.kind == 2'd2), {tag, " tmr_wr"}, 32'(tmr_wr), 32'(eff_wr && v.kind == 2'd2));
      if (v.kind == 2'd1) begin
         chk(ifc_core == v.sel[1:0], {tag, " ifc_core"}, 32'(ifc_core), 32'(v.sel[1:0]));
         chk(ifc_off == v.off, {tag, " ifc_off"}, 32'(ifc_off), 32'(v.off));
      end
      if (v.kind == 2'd2) begin
         chk(tmr_idx == v.sel, {tag, " tmr_idx"}, 32'(tmr_idx), 32'(v.sel));
         chk(tmr_off == v.off[3:0], {tag, " tmr_off"}, 32'(tmr_off), 32'(v.off[3:0]));
      end
      if (eff_wr && v.kind != 2'd0) begin
         chk(dn_wdata == v.wdata, {tag, " wdata"}, dn_wdata, v.wdata);
      end
      @(posedge clk);
      #2;
      chk(rsp_valid == 1'b1, {tag, " R9 valid"}, 32'(rsp_valid), 32'd1);
      chk(rsp_err == v.err, {tag, " err"}, 32'(rsp_err), 32'(v.err));
      chk(rsp_rdata == v.rdata, {tag, " rdata"}, rsp_rdata, v.rdata);
      req_rd = 1'b0;
      req_wr = 1'b0;
   endtask

   function automatic vec_t mk(input logic [3:0] req, input logic rd, input logic wr,
                               input logic [31:0] addr, input logic [31:0] wdata,
                               input logic err, input logic [31:0] rdata);
      vec_t v;
      v       = '0;
      v.req   = req;
      v.rd    = rd;
      v.wr    = wr;
      v.addr  = addr;
      v.wdata = wdata;
      v.err   = err;
      v.rdata = rdata;
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R9: nothing is valid during reset
      chk(rsp_valid == 1'b0, "R9 reset valid", 32'(rsp_valid), 32'd0);
      chk(rsp_err == 1'b0, "R9 reset err", 32'(rsp_err), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: control bit is 0 after reset
      run_acc(mk(4'd2, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0));

      for (int i = 0; i < NV; i++) begin
         run_acc(VECS[i]);
      end

      // R2: writes keep only bit 0
      run_acc(mk(4'd2, 1'b0, 1'b1, 32'h0, 32'hFFFF_FFFF, 1'b0, 32'h0));
      run_acc(mk(4'd2, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h1));
      // R3: write to invalidate offset is accepted and leaves the bit alone
      run_acc(mk(4'd3, 1'b0, 1'b1, 32'h0000_000C, 32'h0, 1'b0, 32'h0));
      run_acc(mk(4'd3, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h1));
      // R4: errored write to 0x008 changes nothing
      run_acc(mk(4'd4, 1'b0, 1'b1, 32'h0000_0008, 32'h0, 1'b1, 32'h0));
      run_acc(mk(4'd4, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h1));
      // R10: read and write together act as a read; bit stays 1
      run_acc(mk(4'd10, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0, 32'h1));
      run_acc(mk(4'd10, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h1));
      // R2: a write of 2 clears the bit
      run_acc(mk(4'd2, 1'b0, 1'b1, 32'h0, 32'h2, 1'b0, 32'h0));
      run_acc(mk(4'd2, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0));
      // R10: read+write on a timer page strobes only the read
      begin
         vec_t v;
         v = mk(4'd10, 1'b1, 1'b1, 32'h0000_0624, 32'h9, 1'b0, 32'hB000_0104);
         v.core = 2'd0;
         v.kind = 2'd2;
         v.sel  = 3'd1;
         v.off  = 8'h04;
         run_acc(v);
      end

      // R11 and R9: idle cycle gives no strobe and no response
      @(negedge clk);
      req_addr = 32'h0000_0104;
      #2;
      chk(!(ifc_rd || ifc_wr || tmr_rd || tmr_wr), "R11 idle strobes",
          {28'd0, ifc_rd, ifc_wr, tmr_rd, tmr_wr}, 32'd0);
      @(posedge clk);
      #2;
      chk(rsp_valid == 1'b0, "R9 idle response", 32'(rsp_valid), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule